// File: doc/BRIEF.md
# Length-Prefixed CRC Block Framer

This block frames and deframes byte-serial blocks. Each block opens with a count byte, carries a payload and closes with a 16-bit CRC trailer. The count byte gives the size of the whole block: itself, the payload and the two trailer bytes. The CRC covers the count byte and the payload.

On the transmit side, payload bytes arrive on a valid/ready stream and are held in a small buffer until the final byte is marked. The block then emits the count byte, the buffered payload and the CRC trailer on consecutive cycles, and stalls the input stream while it does so.

On the receive side, the block takes one byte per valid cycle. It checks the count byte against the legal range and forwards the payload bytes as they arrive. It recomputes the CRC and, at the end of the block, raises a done strobe with separate flags for a bad length and a bad CRC. A block whose count is out of range is swallowed over a bounded number of bytes. An abort input returns the receiver to waiting for a count byte at any time.

Top module: `lpcrc_framer`

## Requirements
- R1: The first byte the transmitter emits for a block equals the payload byte count plus 3.
- R2: The trailer value is a CRC with generator 0x8005 and an initial register of 0, computed over the count byte and the payload bytes. Each byte is fed least significant bit first. Per bit, the feedback is the input bit XOR register bit 15, the register shifts left by one, and the register is XORed with 0x8005 when the feedback is 1.
- R3: The transmitter emits count, payload, CRC low byte and CRC high byte with tx_valid high on consecutive cycles. The CRC high byte is the last byte of the block.
- R4: A payload byte is taken only in a cycle with s_valid and s_ready both high. s_ready is low for exactly count cycles, starting the cycle after the final payload byte is taken.
- R5: When 36 payload bytes have been taken without s_last, the transmitter closes the block as if the 36th byte carried s_last, giving a count of 39.
- R6: The receiver presents each payload byte of a block with a legal count on pl_data with pl_valid high for one cycle. It never presents the count byte or the trailer bytes.
- R7: The cycle after the final trailer byte of a block with a legal count, rx_done pulses for one cycle. At the same time crc_err reads 1 exactly when the received trailer (low byte first) differs from the CRC of R2.
- R8: A count byte below 4 or above 39 sets len_err, pulses rx_done the following cycle, leaves crc_err at 0 and produces no payload output.
- R9: After an out-of-range count c, the receiver discards the next min(c,39)-1 bytes, or none when c is 0. It then treats the following byte as a new count byte.
- R10: A cycle with rx_abort high returns the receiver to waiting for a count byte, with no rx_done for the abandoned block.
- R11: crc_err and len_err hold their value until the next count byte is taken, which clears both. They are never high together.
- R12: After reset, s_ready is 1 and tx_valid, pl_valid, rx_done, crc_err and len_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Transmit payload byte valid |
| s_ready | output | 1 | Transmitter can take a payload byte |
| s_data | input | 8 | Transmit payload byte |
| s_last | input | 1 | Marks the final payload byte of a block |
| tx_valid | output | 1 | Framed output byte valid |
| tx_data | output | 8 | Framed output byte |
| rx_valid | input | 1 | Incoming framed byte valid |
| rx_data | input | 8 | Incoming framed byte |
| rx_abort | input | 1 | Drops the block in progress |
| pl_valid | output | 1 | Received payload byte valid |
| pl_data | output | 8 | Received payload byte |
| rx_done | output | 1 | One-cycle end-of-block strobe |
| crc_err | output | 1 | Last block failed its CRC check |
| len_err | output | 1 | Last block had an out-of-range count |

## Verification
The hardest situation to reach is the receiver discarding after a bad count and then resynchronising on exactly the right byte. The bench sends a count of 200 followed by 38 filler bytes whose value is itself a legal count, and then a correct block. The correct block is only accepted if the discard window ends exactly where it should. Transmitter output is looped back into the receiver, so the CRC bit order is checked end to end as well as against an independent bench model. The 36-byte auto-close is reached by streaming a payload that never asserts s_last.

// File: rtl/lpcrc_pkg.sv
package lpcrc_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef enum logic [2:0] {TX_FILL, TX_HEAD, TX_BODY, TX_CRCL, TX_CRCH} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_BODY, RX_SKIP} rx_state_e;

  // One byte into the CRC register, least significant data bit first.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c_in,
                                                input logic [BYTE_W-1:0] d,
                                                input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/lpcrc_crc16.sv
module lpcrc_crc16 import lpcrc_pkg::*; #(
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] base;
  assign base = clr ? '0 : crc;

  always_ff @(posedge clk) begin
    if (rst)          crc <= '0;
    else if (en)      crc <= crc_step(base, din, POLY);
    else if (clr)     crc <= '0;
  end
endmodule

// File: rtl/lpcrc_tx.sv
module lpcrc_tx import lpcrc_pkg::*; #(
  parameter int MAX_LEN = 39,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  localparam int MAX_PL = MAX_LEN - 3;
  localparam int AW     = $clog2(MAX_PL);
  localparam int DEPTH  = 1 << AW;

  tx_state_e         state;
  logic [AW-1:0]     wr_ptr, idx, len_m1, rd_addr;
  logic [BYTE_W-1:0] cnt, rd_q, crc_din;
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [CRC_W-1:0]  crc;
  logic              acc, wr_full, crc_en, crc_clr;

  assign s_ready = (state == TX_FILL);
  assign acc     = s_ready && s_valid;
  assign wr_full = (wr_ptr == AW'(MAX_PL - 1));

  // Payload buffer, written and read in the style of a simple dual-port RAM.
  always_ff @(posedge clk) begin
    if (acc) mem[wr_ptr] <= s_data;
    rd_q <= mem[rd_addr];
  end

  always_comb begin
    rd_addr = '0;
    crc_en  = 1'b0;
    crc_clr = 1'b0;
    crc_din = rd_q;
    case (state)
      TX_HEAD: begin crc_en = 1'b1; crc_din = cnt; end
      TX_BODY: begin crc_en = 1'b1; rd_addr = idx + AW'(1); end
      TX_CRCH: crc_clr = 1'b1;
      default: ;
    endcase
  end

  lpcrc_crc16 #(.POLY(POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_FILL;
      wr_ptr   <= '0;
      idx      <= '0;
      len_m1   <= '0;
      cnt      <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= (state != TX_FILL);
      case (state)
        TX_FILL: if (acc) begin
          if (s_last || wr_full) begin
            len_m1 <= wr_ptr;
            cnt    <= BYTE_W'(wr_ptr) + BYTE_W'(4);
            wr_ptr <= '0;
            state  <= TX_HEAD;
          end else begin
            wr_ptr <= wr_ptr + AW'(1);
          end
        end
        TX_HEAD: begin
          tx_data <= cnt;
          idx     <= '0;
          state   <= TX_BODY;
        end
        TX_BODY: begin
          tx_data <= rd_q;
          idx     <= idx + AW'(1);
          if (idx == len_m1) state <= TX_CRCL;
        end
        TX_CRCL: begin
          tx_data <= crc[BYTE_W-1:0];
          state   <= TX_CRCH;
        end
        TX_CRCH: begin
          tx_data <= crc[CRC_W-1:BYTE_W];
          state   <= TX_FILL;
        end
        default: state <= TX_FILL;
      endcase
    end
  end
endmodule

// File: rtl/lpcrc_rx.sv
module lpcrc_rx import lpcrc_pkg::*; #(
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 39,
  parameter logic [CRC_W-1:0] POLY = 16'h8005
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_abort,
  output logic              pl_valid,
  output logic [BYTE_W-1:0] pl_data,
  output logic              rx_done,
  output logic              crc_err,
  output logic              len_err
);
  rx_state_e         state;
  logic [BYTE_W-1:0] rem, lo_byte, skip;
  logic [CRC_W-1:0]  crc;
  logic              in_range, take, crc_clr, crc_en;

  assign take     = rx_valid && !rx_abort;
  assign in_range = (rx_data >= BYTE_W'(MIN_LEN)) && (rx_data <= BYTE_W'(MAX_LEN));

  always_comb begin
    if (rx_data == '0)                     skip = '0;
    else if (rx_data > BYTE_W'(MAX_LEN))   skip = BYTE_W'(MAX_LEN - 1);
    else                                   skip = rx_data - BYTE_W'(1);
  end

  assign crc_clr = take && (state == RX_IDLE);
  assign crc_en  = take && ((state == RX_IDLE && in_range) ||
                            (state == RX_BODY && rem > BYTE_W'(2)));

  lpcrc_crc16 #(.POLY(POLY)) u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .din(rx_data), .crc(crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      rem      <= '0;
      lo_byte  <= '0;
      pl_valid <= 1'b0;
      pl_data  <= '0;
      rx_done  <= 1'b0;
      crc_err  <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      pl_valid <= 1'b0;
      rx_done  <= 1'b0;
      if (rx_abort) begin
        state <= RX_IDLE;
      end else if (rx_valid) begin
        case (state)
          RX_IDLE: begin
            crc_err <= 1'b0;
            if (in_range) begin
              len_err <= 1'b0;
              rem     <= rx_data - BYTE_W'(1);
              state   <= RX_BODY;
            end else begin
              len_err <= 1'b1;
              rx_done <= 1'b1;
              rem     <= skip;
              if (skip != '0) state <= RX_SKIP;
            end
          end
          RX_BODY: begin
            rem <= rem - BYTE_W'(1);
            if (rem > BYTE_W'(2)) begin
              pl_valid <= 1'b1;
              pl_data  <= rx_data;
            end else if (rem == BYTE_W'(2)) begin
              lo_byte <= rx_data;
            end else begin
              rx_done <= 1'b1;
              crc_err <= ({rx_data, lo_byte} != crc);
              state   <= RX_IDLE;
            end
          end
          RX_SKIP: begin
            rem <= rem - BYTE_W'(1);
            if (rem == BYTE_W'(1)) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lpcrc_framer.sv
module lpcrc_framer import lpcrc_pkg::*; #(
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 39,
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [7:0] s_data,
  input  logic       s_last,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_abort,
  output logic       pl_valid,
  output logic [7:0] pl_data,
  output logic       rx_done,
  output logic       crc_err,
  output logic       len_err
);
  lpcrc_tx #(.MAX_LEN(MAX_LEN), .POLY(POLY)) u_tx (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  lpcrc_rx #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .POLY(POLY)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_abort(rx_abort), .pl_valid(pl_valid), .pl_data(pl_data),
    .rx_done(rx_done), .crc_err(crc_err), .len_err(len_err)
  );
endmodule

// File: rtl/lpcrc_framer_chk.sv
module lpcrc_framer_chk #(
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 39
) (
  input logic       clk,
  input logic       rst,
  input logic       s_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       pl_valid,
  input logic       rx_done,
  input logic       crc_err,
  input logic       len_err
);
  AST_TX_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> (tx_data >= 8'(MIN_LEN) && tx_data <= 8'(MAX_LEN))); // R1
  AST_READY_DROP_EMITS: assert property (@(posedge clk) disable iff (rst)
    $fell(s_ready) |=> tx_valid); // R4
  AST_PAYLOAD_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    !(pl_valid && rx_done)); // R6
  AST_LEN_NO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !pl_valid); // R8
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(crc_err && len_err)); // R11
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!rx_done && !$past(rx_done)) |-> ($stable(crc_err) || !crc_err)); // R11
endmodule

bind lpcrc_framer lpcrc_framer_chk #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst(rst), .s_ready(s_ready), .tx_valid(tx_valid), .tx_data(tx_data),
  .pl_valid(pl_valid), .rx_done(rx_done), .crc_err(crc_err), .len_err(len_err)
);

// File: tb/test_lpcrc_framer.sv
module test_lpcrc_framer;
  localparam int MAX_PL = 36;
  // {payload length, seed, use s_last}
  localparam int VEC [8][3] = '{'{1, 3, 1}, '{2, 11, 1}, '{5, 40, 1}, '{17, 9, 1},
                                '{35, 77, 1}, '{36, 5, 1}, '{36, 21, 0}, '{10, 200, 1}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, s_valid, s_ready, s_last, tx_valid, rx_valid, rx_abort;
  logic pl_valid, rx_done, crc_err, len_err;
  logic [7:0] s_data, tx_data, rx_data, pl_data;

  lpcrc_framer i_lpcrc_framer (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_abort(rx_abort), .pl_valid(pl_valid), .pl_data(pl_data),
    .rx_done(rx_done), .crc_err(crc_err), .len_err(len_err)
  );

  int checks = 0, fails = 0;
  logic [7:0] blk [64];
  int blk_n;
  logic [7:0] cap [64];
  logic [7:0] rcap [64];
  int cap_n = 0, rn = 0, done_n = 0;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 31 + i * 17 + (i >> 2)) & 255);
  endfunction

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = blk[k][b] ^ c[15];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0);
      end
    return c;
  endfunction

  task automatic make_blk(input int len, input int seed);
    logic [15:0] c;
    blk[0] = 8'(len + 3);
    for (int i = 0; i < len; i++) blk[i+1] = pat(seed, i);
    c = ref_crc(len + 1);
    blk[len+1] = c[7:0];
    blk[len+2] = c[15:8];
    blk_n = len + 3;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_valid && cap_n < 64) begin cap[cap_n] = tx_data; cap_n++; end
      if (pl_valid && rn < 64) begin rcap[rn] = pl_data; rn++; end
      if (rx_done) done_n++;
    end
  end

  task automatic send_payload(input int len, input int seed, input bit use_last);
    int lo;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      s_valid = 1'b1;
      s_data  = pat(seed, i);
      s_last  = use_last && (i == len - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    lo = 0;
    while (!s_ready && lo < 100) begin lo++; @(negedge clk); end
    chk(lo == len + 3, "R4 ready-low cycles", lo, len + 3);
  endtask

  task automatic send_rx(input int n, input bit from_cap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = from_cap ? cap[i] : blk[i];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_good_rx(input int len, input string tag);
    int bad = 0;
    for (int i = 0; i < len; i++) if (rcap[i] !== blk[i+1]) bad++;
    chk(rn == len, {tag, " payload count"}, rn, len);
    chk(bad == 0, {tag, " payload bytes"}, bad, 0);
    chk(done_n == 1, {tag, " done pulses"}, done_n, 1);
    chk(crc_err == 1'b0 && len_err == 1'b0, {tag, " flags clear"}, {crc_err, len_err}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int len, bad;
    rst = 1'b1; s_valid = 1'b0; s_last = 1'b0; s_data = '0;
    rx_valid = 1'b0; rx_data = '0; rx_abort = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(s_ready && !tx_valid && !pl_valid && !rx_done && !crc_err && !len_err,
        "R12 reset outputs", {s_ready, tx_valid, pl_valid, rx_done, crc_err, len_err}, 32);

    // Table: transmit, compare with model, then loop back into the receiver.
    for (int v = 0; v < 8; v++) begin
      len = VEC[v][0];
      make_blk(len, VEC[v][1]);
      cap_n = 0;
      send_payload(len, VEC[v][1], VEC[v][2] != 0);
      repeat (4) @(negedge clk);
      chk(cap_n == len + 3, "R3 framed length", cap_n, len + 3);
      chk(cap[0] == blk[0], VEC[v][2] != 0 ? "R1 count byte" : "R5 auto-close count",
          cap[0], blk[0]);
      bad = 0;
      for (int i = 1; i <= len; i++) if (cap[i] !== blk[i]) bad++;
      chk(bad == 0, "R3 payload order", bad, 0);
      chk(cap[len+1] == blk[len+1], "R2 crc low byte", cap[len+1], blk[len+1]);
      chk(cap[len+2] == blk[len+2], "R3 crc high byte last", cap[len+2], blk[len+2]);
      rn = 0; done_n = 0;
      send_rx(len + 3, 1'b1);
      check_good_rx(len, "R6 R7 loopback");
    end

    // R7 corrupted trailer
    make_blk(5, 3);
    blk[7] = blk[7] ^ 8'h01;
    rn = 0; done_n = 0;
    send_rx(8, 1'b0);
    chk(done_n == 1 && crc_err == 1'b1 && len_err == 1'b0, "R7 crc error flagged",
        {done_n[1:0], crc_err, len_err}, 6);
    // R11 flag cleared by next good block
    make_blk(4, 8);
    rn = 0; done_n = 0;
    send_rx(7, 1'b0);
    check_good_rx(4, "R11 clear after crc error");

    // R8 R9: count 3 skips two bytes, then a good block
    blk[0] = 8'd3; blk[1] = 8'd7; blk[2] = 8'd7;
    rn = 0; done_n = 0;
    send_rx(3, 1'b0);
    chk(done_n == 1 && len_err == 1'b1 && crc_err == 1'b0 && rn == 0, "R8 short count",
        {done_n[1:0], len_err, crc_err}, 6);
    make_blk(6, 14);
    rn = 0; done_n = 0;
    send_rx(9, 1'b0);
    check_good_rx(6, "R9 resync after short count");

    // R9: count 200 discards exactly 38 bytes whose value is a legal count
    blk[0] = 8'd200;
    for (int i = 1; i <= 38; i++) blk[i] = 8'd5;
    rn = 0; done_n = 0;
    send_rx(39, 1'b0);
    chk(done_n == 1 && len_err == 1'b1 && rn == 0, "R9 long count discard",
        {done_n[1:0], len_err}, 3);
    make_blk(3, 60);
    rn = 0; done_n = 0;
    send_rx(6, 1'b0);
    check_good_rx(3, "R9 resync after long count");

    // R9: count 0 discards nothing
    blk[0] = 8'd0;
    rn = 0; done_n = 0;
    send_rx(1, 1'b0);
    chk(len_err == 1'b1 && done_n == 1, "R8 zero count", {len_err, done_n[1:0]}, 5);
    make_blk(2, 90);
    rn = 0; done_n = 0;
    send_rx(5, 1'b0);
    check_good_rx(2, "R9 no discard for zero");

    // R10 abort mid-block
    make_blk(7, 33);
    rn = 0; done_n = 0;
    send_rx(4, 1'b0);
    @(negedge clk); rx_abort = 1'b1;
    @(negedge clk); rx_abort = 1'b0;
    @(negedge clk);
    chk(done_n == 0, "R10 no done on abort", done_n, 0);
    make_blk(5, 101);
    rn = 0; done_n = 0;
    send_rx(8, 1'b0);
    check_good_rx(5, "R10 block after abort");

    finish_run();
  end
endmodule